// File: doc/BRIEF.md
# Host-to-controller command mailbox

This block is a register-mapped mailbox that connects a host bus to an embedded power-management controller. The host may first load a source pointer, a destination pointer and up to four payload words. It then writes a command word. Accepting that command marks the mailbox busy and sends a one-cycle doorbell to the controller side. The controller side sees the stored command, the pointers, the payload and a payload word count.

The controller side answers with a done strobe that carries an error flag and an error code. Before that strobe it may load up to four reply words into a read buffer. The host learns of completion in one of two ways. It can poll the status word until busy drops. If the command asked for an interrupt, it can instead wait for the interrupt line and then clear the flag by writing a one to it.

The host port is a plain 32-bit register port. Writes take effect at the clock edge. Reads return the addressed register in the same cycle.

Top module: `hcmd_mailbox`

## Requirements
- R1: After reset every register reads zero, `host_irq` is low and `ctl_doorbell` is low.
- R2: A host write to offset 0x00 while not busy does four things at the next edge. It stores the write data as the command, sets busy (status bit 0), clears the error bit and the error code, and raises `ctl_doorbell` for exactly one cycle.
- R3: A host write to offset 0x00 while busy is dropped. The stored command keeps its value and no doorbell is raised.
- R4: A `ctl_done` pulse while busy clears busy at the next edge. It loads status bit 1 from `ctl_err` and status bits 23:16 from `ctl_ecode`, or loads zero into those bits when `ctl_err` is low. A `ctl_done` pulse while not busy changes nothing. Error codes 0 to 7 mean: no error, unsupported, not serviced, cannot serve, invalid, failed, security failure, unsigned image.
- R5: At completion the interrupt flag (status bit 2) is set only if bit 8 of the stored command is one. `host_irq` is high exactly while that flag is set and command bit 8 is one.
- R6: A host write to offset 0x04 with bit 2 set clears the interrupt flag. If bit 2 is zero the write has no effect. When a completion sets the flag in the same cycle as a clear, the set wins. Busy, error and error code cannot be written by the host.
- R7: The source pointer (offset 0x08) and destination pointer (offset 0x0C) are host read/write registers, and they also drive `ctl_sptr` and `ctl_dptr`.
- R8: The write buffer holds word i at offset 0x80+4i, for i from 0 to 3. It is host read/write and appears at `ctl_wbuf[32i+31:32i]`.
- R9: The controller side fills read buffer word i through `ctl_rbuf_we`, `ctl_rbuf_idx` and `ctl_rbuf_data`. The host reads that word at offset 0x90+4i. Host writes to the read buffer are ignored.
- R10: A host access that is not word aligned, or that hits no register, reads zero and writes nothing.
- R11: The command fields are: opcode in bits 7:0, interrupt request in bit 8, subcommand in bits 15:12, and payload length in bytes in bits 20:16. `ctl_len_words` equals that length rounded up to whole 32-bit words, capped at four.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 8 | Host byte address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for `host_addr` |
| host_irq | output | 1 | Completion interrupt to the host |
| ctl_doorbell | output | 1 | One-cycle pulse when a command is accepted |
| ctl_cmd | output | 32 | Stored command word |
| ctl_len_words | output | 3 | Payload length in words |
| ctl_sptr | output | 32 | Source pointer |
| ctl_dptr | output | 32 | Destination pointer |
| ctl_wbuf | output | 128 | Payload words, word 0 in the low bits |
| ctl_done | input | 1 | Controller completion strobe |
| ctl_err | input | 1 | Completion reports an error |
| ctl_ecode | input | 8 | Error code sent with `ctl_done` |
| ctl_rbuf_we | input | 1 | Read buffer write strobe |
| ctl_rbuf_idx | input | 2 | Read buffer word index |
| ctl_rbuf_data | input | 32 | Read buffer write data |

## Verification
Commands are run in two ways: with the interrupt-request bit, where completion is seen on `host_irq`, and without it, where only polling the status word shows completion. This separates the interrupt path from the busy path.

Several patterns each isolate one rule:
- A second command written while busy shows whether the busy gate drops it.
- Completions are given with an error and without one. With the error low but a nonzero code supplied, the test shows whether the code is suppressed.
- A completion while idle shows whether it is ignored.
- A clear that lands in the same cycle as a completion shows which one has priority.
- Payload lengths of 1, 5, 16 and 20 bytes cover the round-up and the cap.
- A full address sweep separates mapped offsets from unmapped ones and from misaligned ones.

// File: rtl/hcmd_mbx_pkg.sv
package hcmd_mbx_pkg;

   // Word offsets (byte address bits 7:2) of the host map
   localparam logic [5:0] WOFS_CMD  = 6'h00;
   localparam logic [5:0] WOFS_STAT = 6'h01;
   localparam logic [5:0] WOFS_SRC  = 6'h02;
   localparam logic [5:0] WOFS_DST  = 6'h03;
   localparam logic [3:0] BOFS_WBUF = 4'h8;   // byte address bits 7:4
   localparam logic [3:0] BOFS_RBUF = 4'h9;

   // Command word fields
   localparam int IRQ_BIT = 8;
   localparam int SUB_LSB = 12;
   localparam int SUB_W   = 4;
   localparam int LEN_LSB = 16;
   localparam int LEN_W   = 5;

   // Status word fields
   localparam int ST_BUSY     = 0;
   localparam int ST_ERR      = 1;
   localparam int ST_FLAG     = 2;
   localparam int ST_CODE_LSB = 16;

   localparam int BUF_IDX_W = 2;
   localparam int BUF_MAX   = 4;

   typedef enum logic [7:0] {
      RC_OK          = 8'd0,
      RC_UNSUPPORTED = 8'd1,
      RC_UNSERVICED  = 8'd2,
      RC_CANNOT      = 8'd3,
      RC_INVALID     = 8'd4,
      RC_FAILED      = 8'd5,
      RC_SECURITY    = 8'd6,
      RC_UNSIGNED    = 8'd7
   } mbx_rc_e;

   function automatic int unsigned words_of(int unsigned nbytes, int unsigned cap);
      int unsigned w;
      w = (nbytes + 3) / 4;
      return (w > cap) ? cap : w;
   endfunction

endpackage

// File: rtl/hcmd_mbx_wordbuf.sv
module hcmd_mbx_wordbuf #(
   parameter int WORDS  = 4,
   parameter int DATA_W = 32,
   parameter int IDX_W  = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    we,
   input  logic [IDX_W-1:0]        idx,
   input  logic [DATA_W-1:0]       wdata,
   output logic [WORDS*DATA_W-1:0] flat
);

   generate
      for (genvar g = 0; g < WORDS; g++) begin : g_word
         logic [DATA_W-1:0] word_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               word_q <= '0;
            else if (we && idx == IDX_W'(g))
               word_q <= wdata;
         end
         assign flat[g*DATA_W +: DATA_W] = word_q;
      end
   endgenerate

endmodule

// File: rtl/hcmd_mbx_ctrl.sv
module hcmd_mbx_ctrl
   import hcmd_mbx_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int ECODE_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_wr,
   input  logic [DATA_W-1:0]  cmd_wdata,
   input  logic               stat_wr,
   input  logic               clr_bit,
   input  logic               done,
   input  logic               err_in,
   input  logic [ECODE_W-1:0] ecode_in,
   output logic [DATA_W-1:0]  cmd_q,
   output logic               busy,
   output logic               err,
   output logic [ECODE_W-1:0] ecode,
   output logic               flag,
   output logic               doorbell,
   output logic               irq
);

   logic accept, finish, flag_set, flag_clr;

   assign accept   = cmd_wr & ~busy;
   assign finish   = done & busy;
   assign flag_set = finish & cmd_q[IRQ_BIT];
   assign flag_clr = stat_wr & clr_bit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q    <= '0;
         busy     <= 1'b0;
         err      <= 1'b0;
         ecode    <= '0;
         flag     <= 1'b0;
         doorbell <= 1'b0;
      end else begin
         doorbell <= accept;
         if (accept) begin
            cmd_q <= cmd_wdata;
            busy  <= 1'b1;
            err   <= 1'b0;
            ecode <= '0;
         end else if (finish) begin
            busy  <= 1'b0;
            err   <= err_in;
            ecode <= err_in ? ecode_in : '0;
         end
         flag <= flag_set | (flag & ~flag_clr);
      end
   end

   assign irq = flag & cmd_q[IRQ_BIT];

endmodule

// File: rtl/hcmd_mailbox.sv
module hcmd_mailbox
   import hcmd_mbx_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 32,
   parameter int PAY_WORDS = 4,
   parameter int ECODE_W   = 8,
   localparam int CNT_W    = $clog2(PAY_WORDS + 1)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        host_wr,
   input  logic [ADDR_W-1:0]           host_addr,
   input  logic [DATA_W-1:0]           host_wdata,
   output logic [DATA_W-1:0]           host_rdata,
   output logic                        host_irq,
   output logic                        ctl_doorbell,
   output logic [DATA_W-1:0]           ctl_cmd,
   output logic [CNT_W-1:0]            ctl_len_words,
   output logic [DATA_W-1:0]           ctl_sptr,
   output logic [DATA_W-1:0]           ctl_dptr,
   output logic [PAY_WORDS*DATA_W-1:0] ctl_wbuf,
   input  logic                        ctl_done,
   input  logic                        ctl_err,
   input  logic [ECODE_W-1:0]          ctl_ecode,
   input  logic                        ctl_rbuf_we,
   input  logic [BUF_IDX_W-1:0]        ctl_rbuf_idx,
   input  logic [DATA_W-1:0]           ctl_rbuf_data
);

   // Elaboration-time parameter checks
   generate
      if (ADDR_W < 8)
         $error("hcmd_mailbox: ADDR_W must be at least 8");
      if (DATA_W < ST_CODE_LSB + ECODE_W || DATA_W < LEN_LSB + LEN_W)
         $error("hcmd_mailbox: DATA_W too narrow for the field layout");
      if (ECODE_W < 1 || ECODE_W > 8)
         $error("hcmd_mailbox: ECODE_W must be 1..8");
      if (PAY_WORDS < 1 || PAY_WORDS > BUF_MAX)
         $error("hcmd_mailbox: PAY_WORDS must be 1..4");
   endgenerate

   // Address decode
   logic       hi_ok, base_ok;
   logic [5:0] wofs;
   logic [1:0] bidx;
   logic       in_range;

   generate
      if (ADDR_W > 8) begin : g_hi
         assign hi_ok = (host_addr[ADDR_W-1:8] == '0);
      end else begin : g_nohi
         assign hi_ok = 1'b1;
      end
   endgenerate

   assign base_ok  = hi_ok && (host_addr[1:0] == 2'b00);
   assign wofs     = host_addr[7:2];
   assign bidx     = host_addr[3:2];
   assign in_range = (32'(bidx) < PAY_WORDS);

   logic hit_cmd, hit_stat, hit_src, hit_dst, hit_wbuf, hit_rbuf;
   assign hit_cmd  = base_ok && (wofs == WOFS_CMD);
   assign hit_stat = base_ok && (wofs == WOFS_STAT);
   assign hit_src  = base_ok && (wofs == WOFS_SRC);
   assign hit_dst  = base_ok && (wofs == WOFS_DST);
   assign hit_wbuf = base_ok && (host_addr[7:4] == BOFS_WBUF) && in_range;
   assign hit_rbuf = base_ok && (host_addr[7:4] == BOFS_RBUF) && in_range;

   // Command / status engine
   logic               busy_w, err_w, flag_w;
   logic [ECODE_W-1:0] ecode_w;

   hcmd_mbx_ctrl #(.DATA_W(DATA_W), .ECODE_W(ECODE_W)) ctrl_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_wr   (host_wr && hit_cmd),
      .cmd_wdata(host_wdata),
      .stat_wr  (host_wr && hit_stat),
      .clr_bit  (host_wdata[ST_FLAG]),
      .done     (ctl_done),
      .err_in   (ctl_err),
      .ecode_in (ctl_ecode),
      .cmd_q    (ctl_cmd),
      .busy     (busy_w),
      .err      (err_w),
      .ecode    (ecode_w),
      .flag     (flag_w),
      .doorbell (ctl_doorbell),
      .irq      (host_irq)
   );

   // Pointer registers
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_sptr <= '0;
         ctl_dptr <= '0;
      end else if (host_wr) begin
         if (hit_src) ctl_sptr <= host_wdata;
         if (hit_dst) ctl_dptr <= host_wdata;
      end
   end

   // Payload and reply buffers
   logic [PAY_WORDS*DATA_W-1:0] rbuf_flat;

   hcmd_mbx_wordbuf #(.WORDS(PAY_WORDS), .DATA_W(DATA_W), .IDX_W(BUF_IDX_W)) wbuf_i (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (host_wr && hit_wbuf),
      .idx  (bidx),
      .wdata(host_wdata),
      .flat (ctl_wbuf)
   );

   hcmd_mbx_wordbuf #(.WORDS(PAY_WORDS), .DATA_W(DATA_W), .IDX_W(BUF_IDX_W)) rbuf_i (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (ctl_rbuf_we),
      .idx  (ctl_rbuf_idx),
      .wdata(ctl_rbuf_data),
      .flat (rbuf_flat)
   );

   logic [DATA_W-1:0] wbuf_w [PAY_WORDS];
   logic [DATA_W-1:0] rbuf_w [PAY_WORDS];
   generate
      for (genvar g = 0; g < PAY_WORDS; g++) begin : g_unpack
         assign wbuf_w[g] = ctl_wbuf[g*DATA_W +: DATA_W];
         assign rbuf_w[g] = rbuf_flat[g*DATA_W +: DATA_W];
      end
   endgenerate

   // Status word and read mux
   logic [DATA_W-1:0] stat_word;
   always_comb begin
      stat_word                           = '0;
      stat_word[ST_BUSY]                  = busy_w;
      stat_word[ST_ERR]                   = err_w;
      stat_word[ST_FLAG]                  = flag_w;
      stat_word[ST_CODE_LSB +: ECODE_W]   = ecode_w;
   end

   always_comb begin
      host_rdata = '0;
      if (hit_cmd)       host_rdata = ctl_cmd;
      else if (hit_stat) host_rdata = stat_word;
      else if (hit_src)  host_rdata = ctl_sptr;
      else if (hit_dst)  host_rdata = ctl_dptr;
      else if (hit_wbuf) host_rdata = wbuf_w[bidx];
      else if (hit_rbuf) host_rdata = rbuf_w[bidx];
   end

   // Payload length in words
   assign ctl_len_words = CNT_W'(words_of(32'(ctl_cmd[LEN_LSB +: LEN_W]), PAY_WORDS));

endmodule

// File: rtl/hcmd_mailbox_chk.sv
module hcmd_mailbox_chk
   import hcmd_mbx_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_wr,
   input logic [ADDR_W-1:0] host_addr,
   input logic              clr_bit,
   input logic [DATA_W-1:0] host_rdata,
   input logic              host_irq,
   input logic              ctl_doorbell,
   input logic [DATA_W-1:0] ctl_cmd,
   input logic              ctl_done,
   input logic              busy
);

   logic cmd_sel, stat_sel, mapped;
   assign cmd_sel  = (host_addr == ADDR_W'(0));
   assign stat_sel = (host_addr == ADDR_W'(4));
   assign mapped   = ((host_addr >> 8) == '0) && (host_addr[1:0] == 2'b00) &&
                     ((host_addr[7:4] == 4'h0) || (host_addr[7:4] == 4'h8) ||
                      (host_addr[7:4] == 4'h9));

   p_doorbell_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_doorbell |=> !ctl_doorbell);

   p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && cmd_sel && !busy) |=> (busy && ctl_doorbell));

   p_cmd_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(ctl_cmd));

   p_done_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && ctl_done) |=> !busy);

   p_irq_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(host_irq) |-> $past(busy && ctl_done));

   p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && stat_sel && clr_bit && !(busy && ctl_done)) |=> !host_irq);

   p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !mapped |-> (host_rdata == '0));

endmodule

bind hcmd_mailbox hcmd_mailbox_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .host_wr     (host_wr),
   .host_addr   (host_addr),
   .clr_bit     (host_wdata[2]),
   .host_rdata  (host_rdata),
   .host_irq    (host_irq),
   .ctl_doorbell(ctl_doorbell),
   .ctl_cmd     (ctl_cmd),
   .ctl_done    (ctl_done),
   .busy        (busy_w)
);

// File: tb/hcmd_mailbox_tb_top.sv
module hcmd_mailbox_tb_top;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         host_wr = 1'b0;
   logic [7:0]   host_addr = '0;
   logic [31:0]  host_wdata = '0;
   logic [31:0]  host_rdata;
   logic         host_irq;
   logic         ctl_doorbell;
   logic [31:0]  ctl_cmd;
   logic [2:0]   ctl_len_words;
   logic [31:0]  ctl_sptr, ctl_dptr;
   logic [127:0] ctl_wbuf;
   logic         ctl_done = 1'b0;
   logic         ctl_err = 1'b0;
   logic [7:0]   ctl_ecode = '0;
   logic         ctl_rbuf_we = 1'b0;
   logic [1:0]   ctl_rbuf_idx = '0;
   logic [31:0]  ctl_rbuf_data = '0;

   int checks = 0;
   int fails  = 0;

   always #2 clk = ~clk;   // 250 MHz

   hcmd_mailbox dut_i (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .host_irq(host_irq),
      .ctl_doorbell(ctl_doorbell), .ctl_cmd(ctl_cmd), .ctl_len_words(ctl_len_words),
      .ctl_sptr(ctl_sptr), .ctl_dptr(ctl_dptr), .ctl_wbuf(ctl_wbuf),
      .ctl_done(ctl_done), .ctl_err(ctl_err), .ctl_ecode(ctl_ecode),
      .ctl_rbuf_we(ctl_rbuf_we), .ctl_rbuf_idx(ctl_rbuf_idx), .ctl_rbuf_data(ctl_rbuf_data)
   );

   // Behavioural reference model
   logic [31:0] m_cmd, m_sptr, m_dptr;
   logic [7:0]  m_ecode;
   logic        m_busy, m_err, m_flag, m_door;
   logic [31:0] m_wb [4];
   logic [31:0] m_rb [4];

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cmd = 0; m_sptr = 0; m_dptr = 0; m_ecode = 0;
         m_busy = 0; m_err = 0; m_flag = 0; m_door = 0;
         for (int i = 0; i < 4; i++) begin m_wb[i] = 0; m_rb[i] = 0; end
      end else begin
         automatic logic was_busy = m_busy;
         m_door = 0;
         if (host_wr && host_addr[1:0] == 2'b00) begin
            if (host_addr == 8'h00 && !was_busy) begin
               m_cmd = host_wdata; m_busy = 1; m_err = 0; m_ecode = 0; m_door = 1;
            end
            if (host_addr == 8'h04 && host_wdata[2]) m_flag = 0;
            if (host_addr == 8'h08) m_sptr = host_wdata;
            if (host_addr == 8'h0C) m_dptr = host_wdata;
            if (host_addr[7:4] == 4'h8) m_wb[host_addr[3:2]] = host_wdata;
         end
         if (ctl_done && was_busy) begin
            m_busy = 0; m_err = ctl_err; m_ecode = ctl_err ? ctl_ecode : 8'h0;
            if (m_cmd[8]) m_flag = 1;
         end
         if (ctl_rbuf_we) m_rb[ctl_rbuf_idx] = ctl_rbuf_data;
      end
   end

   function automatic logic [31:0] m_status();
      return {8'h0, m_ecode, 13'h0, m_flag, m_err, m_busy};
   endfunction

   function automatic logic [31:0] mread(logic [7:0] a);
      if (a[1:0] != 2'b00) return 32'h0;
      case (a[7:4])
         4'h0: case (a[3:2])
                  2'd0: return m_cmd;
                  2'd1: return m_status();
                  2'd2: return m_sptr;
                  default: return m_dptr;
               endcase
         4'h8: return m_wb[a[3:2]];
         4'h9: return m_rb[a[3:2]];
         default: return 32'h0;
      endcase
   endfunction

   function automatic string tag_for(logic [7:0] a);
      if (a[1:0] != 2'b00) return "R10";
      if (a == 8'h00) return "R2";
      if (a == 8'h04) return "R4";
      if (a == 8'h08 || a == 8'h0C) return "R7";
      if (a[7:4] == 4'h8) return "R8";
      if (a[7:4] == 4'h9) return "R9";
      return "R10";
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // Per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         automatic int unsigned w = (int'(m_cmd[20:16]) + 3) / 4;
         if (w > 4) w = 4;
         chk("R2 doorbell", {31'h0, ctl_doorbell}, {31'h0, m_door});
         chk("R5 irq", {31'h0, host_irq}, {31'h0, m_flag & m_cmd[8]});
         chk("R3 cmd", ctl_cmd, m_cmd);
         chk("R11 len", {29'h0, ctl_len_words}, w);
         chk("R7 sptr", ctl_sptr, m_sptr);
         chk("R7 dptr", ctl_dptr, m_dptr);
         for (int i = 0; i < 4; i++) chk("R8 wbuf", ctl_wbuf[32*i +: 32], m_wb[i]);
         chk(tag_for(host_addr), host_rdata, mread(host_addr));
      end
   end

   // Stimulus tasks: called just after a rising edge
   task automatic wr(logic [7:0] a, logic [31:0] d);
      host_wr = 1; host_addr = a; host_wdata = d;
      @(posedge clk); #1;
      host_wr = 0;
   endtask

   task automatic done(logic e, logic [7:0] code);
      ctl_done = 1; ctl_err = e; ctl_ecode = code;
      @(posedge clk); #1;
      ctl_done = 0; ctl_err = 0; ctl_ecode = 0;
   endtask

   task automatic rbw(logic [1:0] i, logic [31:0] d);
      ctl_rbuf_we = 1; ctl_rbuf_idx = i; ctl_rbuf_data = d;
      @(posedge clk); #1;
      ctl_rbuf_we = 0;
   endtask

   task automatic expect_rd(logic [7:0] a, logic [31:0] exp, string req);
      host_addr = a;
      @(negedge clk);
      chk(req, host_rdata, exp);
      @(posedge clk); #1;
   endtask

   initial begin : watchdog
      repeat (50000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin : main
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      @(posedge clk); #1;

      // R1 reset state
      expect_rd(8'h04, 32'h0, "R1 status");
      chk("R1 irq", {31'h0, host_irq}, 32'h0);
      chk("R1 doorbell", {31'h0, ctl_doorbell}, 32'h0);
      expect_rd(8'h00, 32'h0, "R1 cmd");

      // R7 pointers, R8 payload, R9 host write ignored
      wr(8'h08, 32'hA5A5_0001);
      wr(8'h0C, 32'h5A5A_0002);
      expect_rd(8'h08, 32'hA5A5_0001, "R7");
      chk("R7 dptr port", ctl_dptr, 32'h5A5A_0002);
      for (int i = 0; i < 4; i++) wr(8'h80 + 8'(4*i), 32'h1111_1111 * (i + 1));
      expect_rd(8'h8C, 32'h4444_4444, "R8");
      chk("R8 port", ctl_wbuf[63:32], 32'h2222_2222);
      wr(8'h90, 32'hDEAD_BEEF);
      expect_rd(8'h90, 32'h0, "R9 host write ignored");

      // R2 accept with interrupt request, len 5
      wr(8'h00, 32'h0005_2103);
      chk("R2 doorbell", {31'h0, ctl_doorbell}, 32'h1);
      chk("R11 len5", {29'h0, ctl_len_words}, 32'd2);
      expect_rd(8'h04, 32'h1, "R2 busy");
      // R3 dropped while busy
      wr(8'h00, 32'h0000_0042);
      chk("R3 no doorbell", {31'h0, ctl_doorbell}, 32'h0);
      expect_rd(8'h00, 32'h0005_2103, "R3 cmd kept");
      rbw(2'd0, 32'hCAFE_0000);
      rbw(2'd3, 32'hCAFE_0003);
      expect_rd(8'h9C, 32'hCAFE_0003, "R9");
      // R4 error completion
      done(1'b1, 8'd6);
      expect_rd(8'h04, 32'h0006_0006, "R4 error");
      chk("R5 irq set", {31'h0, host_irq}, 32'h1);
      // R6 clear semantics
      wr(8'h04, 32'h0000_0003);
      chk("R6 no clear", {31'h0, host_irq}, 32'h1);
      wr(8'h04, 32'h0000_0004);
      chk("R6 clear", {31'h0, host_irq}, 32'h0);
      expect_rd(8'h04, 32'h0006_0002, "R6 status");

      // No interrupt request, len 20 clamps, error suppressed code
      wr(8'h00, 32'h0014_0001);
      expect_rd(8'h04, 32'h1, "R2 err cleared");
      chk("R11 clamp", {29'h0, ctl_len_words}, 32'd4);
      done(1'b0, 8'd5);
      expect_rd(8'h04, 32'h0, "R4 no error");
      chk("R5 no irq", {31'h0, host_irq}, 32'h0);
      done(1'b1, 8'd3);
      expect_rd(8'h04, 32'h0, "R4 idle done ignored");

      // R6 set wins over simultaneous clear; len 16
      wr(8'h00, 32'h0010_0107);
      chk("R11 len16", {29'h0, ctl_len_words}, 32'd4);
      ctl_done = 1; ctl_err = 0;
      wr(8'h04, 32'h0000_0004);
      ctl_done = 0;
      chk("R6 set wins", {31'h0, host_irq}, 32'h1);
      wr(8'h04, 32'h0000_0004);
      wr(8'h00, 32'h0001_0000);
      chk("R11 len1", {29'h0, ctl_len_words}, 32'd1);
      done(1'b0, 8'd0);

      // R10 sweep including misaligned and unmapped
      expect_rd(8'h10, 32'h0, "R10");
      expect_rd(8'hA0, 32'h0, "R10");
      expect_rd(8'h81, 32'h0, "R10 misaligned");
      wr(8'h0A, 32'hFFFF_FFFF);
      expect_rd(8'h08, 32'hA5A5_0001, "R10 misaligned write");
      for (int a = 0; a < 256; a++) begin
         host_addr = 8'(a);
         @(posedge clk); #1;
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule